// File: doc/BRIEF.md
# Byte-Parity Registered Bus Transceiver

This block joins two 16-bit buses, an A side and a B side, with one stored path in each direction. Each path carries two data bytes and one parity bit per byte. Each path has its own latch enable, its own clock and its own active-low output enable. With the latch enable high, a path is transparent. With the latch enable low, the path shows the word it caught on the most recent rising edge of its own clock. Stopping that clock turns the path into a plain latch.

Parity handling differs between the two directions:
- The A-to-B path has a mode select. In generate mode it writes fresh parity toward B. In check mode it forwards the incoming parity and tests it.
- The B-to-A path can only check.
- One odd/even select serves both directions. It is the only control the two directions share.

Each direction has one active-low error flag, which covers both of its bytes. A path tests parity on its inputs and stores the result with the word, so the flag always belongs to the word being shown. Output enables are modelled as plain drive-enable outputs. The error flag reads high whenever its direction's output enable is inactive.

Top module: `bpx_xcvr`

## Requirements
- R1: With a direction's latch enable high, that direction's data and parity outputs follow its inputs in the same cycle, with no clock edge needed.
- R2: With the latch enable low and the direction's clock running, the outputs show the word and parity captured on the last rising edge of that direction's clock. A change at the inputs appears only after the next rising edge.
- R3: With the latch enable low and the direction's clock stopped, the outputs hold their value whatever the inputs do. The other direction keeps working on its own controls.
- R4: With `ab_gen` high (generate mode), the B-side parity bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. Each bit is chosen so that the byte plus its bit holds an odd number of ones when `odd_sel` is 1, and an even number when it is 0. The A-side parity inputs are ignored, and `ab_err_n` stays high.
- R5: With `ab_gen` low (check mode), the A-side parity passes unchanged to the B side. `ab_err_n` goes low when either byte disagrees with the sense chosen by `odd_sel`.
- R6: The B-to-A path always forwards B-side parity unchanged and always checks it, in the same bit and byte arrangement as R4. `ab_gen` has no effect on it.
- R7: In stored operation, the error flag reflects the parity of the stored word, not of the word now at the inputs.
- R8: While a direction's `*_oe_n` is 1, its error flag reads 1 and its drive-enable output is 0. While `*_oe_n` is 0, the drive enable is 1 and the flag shows the error state. Each direction is independent of the other.
- R9: A change of `odd_sel` changes the parity sense of both directions at once.
- R10: A synchronous reset, sampled on a direction's clock, clears that direction's stored word, parity and error to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ab_clk | input | 1 | Capture clock of the A-to-B path |
| ba_clk | input | 1 | Capture clock of the B-to-A path |
| rst | input | 1 | Synchronous active-high reset, sampled on each path's clock |
| odd_sel | input | 1 | Parity sense for both paths: 1 odd, 0 even |
| ab_gen | input | 1 | A-to-B mode: 1 generate, 0 check |
| ab_le | input | 1 | A-to-B latch enable (1 transparent) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 transparent) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| a_data_in | input | 16 | Data arriving from the A bus |
| a_par_in | input | 2 | Byte parity arriving from the A bus |
| b_data_in | input | 16 | Data arriving from the B bus |
| b_par_in | input | 2 | Byte parity arriving from the B bus |
| b_data_out | output | 16 | Data driven toward the B bus |
| b_par_out | output | 2 | Parity driven toward the B bus |
| b_drv_en | output | 1 | Drive enable for the B-side outputs |
| ab_err_n | output | 1 | A-to-B parity error flag, active low |
| a_data_out | output | 16 | Data driven toward the A bus |
| a_par_out | output | 2 | Parity driven toward the A bus |
| a_drv_en | output | 1 | Drive enable for the A-side outputs |
| ba_err_n | output | 1 | B-to-A parity error flag, active low |

## Verification
The hardest case to reach is a stored error flag that no longer matches the live inputs. It needs a bad word to be captured on one edge and clean parity presented before the next edge. The bench drives a wrong parity bit, lets one edge of the path's clock capture it, and then corrects the inputs in the low phase. Reading the flag before the following edge shows the stored error. Latched operation is reached the same way: the bench gates one direction's clock off in its low phase and changes that direction's inputs while the other direction keeps capturing.

// File: rtl/bpx_pkg.sv
package bpx_pkg;

    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = 2;
    localparam int unsigned WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_bits_t;

    // Word as held in one direction: data, byte parity, per-byte fault.
    typedef struct packed {
        word_t      data;
        lane_bits_t par;
        lane_bits_t bad;
    } slot_t;

    localparam slot_t SLOT_CLEAR = '0;

    // Bit that brings the ones count of a lane to the chosen sense.
    function automatic logic lane_fill(input logic [LANE_W-1:0] bits, input logic sense);
        return sense ^ (^bits);
    endfunction

    // High when lane plus its parity bit disagrees with the sense.
    function automatic logic lane_bad(input logic [LANE_W-1:0] bits, input logic p,
                                      input logic sense);
        return (^{bits, p}) != sense;
    endfunction

endpackage

// File: rtl/bpx_par_encode.sv
module bpx_par_encode
    import bpx_pkg::*;
#(
    parameter bit GEN_EN = 1'b1
) (
    input  word_t      data_i,
    input  lane_bits_t par_i,
    input  logic       gen_i,
    input  logic       odd_i,
    output slot_t      slot_o
);

    lane_bits_t bad;

    for (genvar g = 0; g < LANES; g++) begin : g_check
        assign bad[g] = lane_bad(data_i[g*LANE_W +: LANE_W], par_i[g], odd_i);
    end

    if (GEN_EN) begin : g_gen
        lane_bits_t fill;
        for (genvar g = 0; g < LANES; g++) begin : g_fill
            assign fill[g] = lane_fill(data_i[g*LANE_W +: LANE_W], odd_i);
        end
        always_comb begin
            slot_o.data = data_i;
            slot_o.par  = gen_i ? fill : par_i;
            slot_o.bad  = gen_i ? '0 : bad;
        end
    end else begin : g_chk_only
        logic unused_gen;
        assign unused_gen = gen_i;
        always_comb begin
            slot_o.data = data_i;
            slot_o.par  = par_i;
            slot_o.bad  = bad;
        end
    end

endmodule

// File: rtl/bpx_dir_store.sv
module bpx_dir_store
    import bpx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       le_i,
    input  logic       oe_n_i,
    input  slot_t      live_i,
    output word_t      data_o,
    output lane_bits_t par_o,
    output logic       drv_en_o,
    output logic       err_n_o
);

    slot_t held_q;
    slot_t shown;

    always_ff @(posedge clk_i) begin
        if (rst_i) held_q <= SLOT_CLEAR;
        else       held_q <= live_i;
    end

    assign shown    = le_i ? live_i : held_q;
    assign data_o   = shown.data;
    assign par_o    = shown.par;
    assign drv_en_o = !oe_n_i;
    assign err_n_o  = oe_n_i || !(|shown.bad);

    AST_CLOCKED_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        !le_i |=> (le_i || (data_o == $past(live_i.data) && par_o == $past(live_i.par)))); // R2

endmodule

// File: rtl/bpx_xcvr_dir.sv
module bpx_xcvr_dir
    import bpx_pkg::*;
#(
    parameter bit GEN_EN = 1'b1
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       le_i,
    input  logic       oe_n_i,
    input  logic       gen_i,
    input  logic       odd_i,
    input  word_t      data_i,
    input  lane_bits_t par_i,
    output word_t      data_o,
    output lane_bits_t par_o,
    output logic       drv_en_o,
    output logic       err_n_o
);

    slot_t live;

    bpx_par_encode #(.GEN_EN(GEN_EN)) i_enc (
        .data_i (data_i),
        .par_i  (par_i),
        .gen_i  (gen_i),
        .odd_i  (odd_i),
        .slot_o (live)
    );

    bpx_dir_store i_store (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .le_i     (le_i),
        .oe_n_i   (oe_n_i),
        .live_i   (live),
        .data_o   (data_o),
        .par_o    (par_o),
        .drv_en_o (drv_en_o),
        .err_n_o  (err_n_o)
    );

endmodule

// File: rtl/bpx_xcvr.sv
module bpx_xcvr (
    input  logic                         ab_clk,
    input  logic                         ba_clk,
    input  logic                         rst,
    input  logic                         odd_sel,
    input  logic                         ab_gen,
    input  logic                         ab_le,
    input  logic                         ab_oe_n,
    input  logic                         ba_le,
    input  logic                         ba_oe_n,
    input  logic [bpx_pkg::WORD_W-1:0]   a_data_in,
    input  logic [bpx_pkg::LANES-1:0]    a_par_in,
    input  logic [bpx_pkg::WORD_W-1:0]   b_data_in,
    input  logic [bpx_pkg::LANES-1:0]    b_par_in,
    output logic [bpx_pkg::WORD_W-1:0]   b_data_out,
    output logic [bpx_pkg::LANES-1:0]    b_par_out,
    output logic                         b_drv_en,
    output logic                         ab_err_n,
    output logic [bpx_pkg::WORD_W-1:0]   a_data_out,
    output logic [bpx_pkg::LANES-1:0]    a_par_out,
    output logic                         a_drv_en,
    output logic                         ba_err_n
);

    localparam int unsigned LW = bpx_pkg::LANE_W;

    bpx_xcvr_dir #(.GEN_EN(1'b1)) i_a2b (
        .clk_i    (ab_clk),
        .rst_i    (rst),
        .le_i     (ab_le),
        .oe_n_i   (ab_oe_n),
        .gen_i    (ab_gen),
        .odd_i    (odd_sel),
        .data_i   (a_data_in),
        .par_i    (a_par_in),
        .data_o   (b_data_out),
        .par_o    (b_par_out),
        .drv_en_o (b_drv_en),
        .err_n_o  (ab_err_n)
    );

    bpx_xcvr_dir #(.GEN_EN(1'b0)) i_b2a (
        .clk_i    (ba_clk),
        .rst_i    (rst),
        .le_i     (ba_le),
        .oe_n_i   (ba_oe_n),
        .gen_i    (1'b0),
        .odd_i    (odd_sel),
        .data_i   (b_data_in),
        .par_i    (b_par_in),
        .data_o   (a_data_out),
        .par_o    (a_par_out),
        .drv_en_o (a_drv_en),
        .err_n_o  (ba_err_n)
    );

    AST_AB_TRANSPARENT: assert property (@(posedge ab_clk) disable iff (rst)
        ab_le |-> b_data_out == a_data_in); // R1

    AST_GEN_COUNT: assert property (@(posedge ab_clk) disable iff (rst)
        (ab_le && ab_gen) |-> ((^{b_data_out[LW-1:0], b_par_out[0]}) == odd_sel)); // R4

    AST_BA_CHECK: assert property (@(posedge ba_clk) disable iff (rst)
        (ba_le && !ba_oe_n && ((^{b_data_in[LW-1:0], b_par_in[0]}) != odd_sel)) |-> !ba_err_n); // R6

    AST_AB_FLAG_MASK: assert property (@(posedge ab_clk) disable iff (rst)
        ab_oe_n |-> (ab_err_n && !b_drv_en)); // R8

    AST_BA_FLAG_MASK: assert property (@(posedge ba_clk) disable iff (rst)
        ba_oe_n |-> (ba_err_n && !a_drv_en)); // R8

endmodule

// File: tb/test_bpx_xcvr.sv
`timescale 1ns/1ps
module test_bpx_xcvr;

    logic clk = 1'b0;
    logic run_ab = 1'b1, run_ba = 1'b1;
    logic ab_clk, ba_clk;
    logic rst = 1'b1;
    logic odd_sel = 1'b1, ab_gen = 1'b0;
    logic ab_le = 1'b0, ab_oe_n = 1'b0, ba_le = 1'b0, ba_oe_n = 1'b0;
    logic [15:0] a_data_in = 16'hFFFF, b_data_in = 16'hFFFF;
    logic [1:0]  a_par_in = 2'b11, b_par_in = 2'b11;
    logic [15:0] b_data_out, a_data_out;
    logic [1:0]  b_par_out, a_par_out;
    logic b_drv_en, a_drv_en, ab_err_n, ba_err_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign ab_clk = clk & run_ab;
    assign ba_clk = clk & run_ba;

    bpx_xcvr i_bpx_xcvr (
        .ab_clk(ab_clk), .ba_clk(ba_clk), .rst(rst), .odd_sel(odd_sel), .ab_gen(ab_gen),
        .ab_le(ab_le), .ab_oe_n(ab_oe_n), .ba_le(ba_le), .ba_oe_n(ba_oe_n),
        .a_data_in(a_data_in), .a_par_in(a_par_in), .b_data_in(b_data_in), .b_par_in(b_par_in),
        .b_data_out(b_data_out), .b_par_out(b_par_out), .b_drv_en(b_drv_en), .ab_err_n(ab_err_n),
        .a_data_out(a_data_out), .a_par_out(a_par_out), .a_drv_en(a_drv_en), .ba_err_n(ba_err_n)
    );

    // odd, gen, data, par in, expected B parity, A-to-B fault, raw check fault
    typedef struct packed {
        logic        odd;
        logic        gen;
        logic [15:0] data;
        logic [1:0]  par;
        logic [1:0]  exp_par;
        logic        exp_bad;
        logic        chk_bad;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        {1'b1, 1'b1, 16'h0000, 2'b00, 2'b11, 1'b0, 1'b1},
        {1'b0, 1'b1, 16'h0000, 2'b11, 2'b00, 1'b0, 1'b1},
        {1'b1, 1'b1, 16'h0103, 2'b00, 2'b01, 1'b0, 1'b1},
        {1'b0, 1'b1, 16'h0103, 2'b10, 2'b10, 1'b0, 1'b0},
        {1'b1, 1'b0, 16'h0103, 2'b01, 2'b01, 1'b0, 1'b0},
        {1'b1, 1'b0, 16'h0103, 2'b00, 2'b00, 1'b1, 1'b1},
        {1'b1, 1'b0, 16'h0103, 2'b11, 2'b11, 1'b1, 1'b1},
        {1'b0, 1'b0, 16'hFF7F, 2'b01, 2'b01, 1'b0, 1'b0},
        {1'b0, 1'b0, 16'hFF7F, 2'b10, 2'b10, 1'b1, 1'b1},
        {1'b1, 1'b1, 16'hA5C3, 2'b11, 2'b11, 1'b0, 1'b0},
        {1'b0, 1'b0, 16'hA5C3, 2'b00, 2'b00, 1'b0, 1'b0}
    };

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        // R10 reset clears both stored words
        repeat (3) @(negedge clk);
        #1;
        cmp("R10 b data", 32'(b_data_out), 32'h0);
        cmp("R10 b par", 32'(b_par_out), 32'h0);
        cmp("R10 ab flag", 32'(ab_err_n), 32'h1);
        cmp("R10 a data", 32'(a_data_out), 32'h0);
        cmp("R10 ba flag", 32'(ba_err_n), 32'h1);
        @(negedge clk);
        rst = 1'b0;

        // Table walk, both paths transparent: R1 R4 R5 R6 R9
        ab_le = 1'b1;
        ba_le = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            odd_sel   = VECS[i].odd;
            ab_gen    = VECS[i].gen;
            a_data_in = VECS[i].data;
            a_par_in  = VECS[i].par;
            b_data_in = VECS[i].data;
            b_par_in  = VECS[i].par;
            #1;
            cmp("R1 b data", 32'(b_data_out), 32'(VECS[i].data));
            cmp("R4/R5 b par", 32'(b_par_out), 32'(VECS[i].exp_par));
            cmp("R4/R5 ab flag", 32'(ab_err_n), 32'(!VECS[i].exp_bad));
            cmp("R1 a data", 32'(a_data_out), 32'(VECS[i].data));
            cmp("R6 a par", 32'(a_par_out), 32'(VECS[i].par));
            cmp("R6 ba flag", 32'(ba_err_n), 32'(!VECS[i].chk_bad));
        end

        // R2 clocked capture
        @(negedge clk);
        ab_le = 1'b0; ba_le = 1'b0; ab_gen = 1'b0; odd_sel = 1'b1;
        a_data_in = 16'h0103; a_par_in = 2'b01;
        @(negedge clk);
        a_data_in = 16'h5A5A; a_par_in = 2'b00;
        #1;
        cmp("R2 holds before edge", 32'(b_data_out), 32'h0103);
        @(negedge clk);
        #1;
        cmp("R2 loads after edge", 32'(b_data_out), 32'h5A5A);

        // R7 stored flag belongs to stored word
        a_data_in = 16'h0103; a_par_in = 2'b00;
        @(negedge clk);
        #1;
        cmp("R7 captured fault", 32'(ab_err_n), 32'h0);
        a_par_in = 2'b01;
        #1;
        cmp("R7 fault kept", 32'(ab_err_n), 32'h0);
        cmp("R7 par kept", 32'(b_par_out), 32'h0);
        @(negedge clk);
        #1;
        cmp("R7 clean after edge", 32'(ab_err_n), 32'h1);

        // R8 flag masking per direction
        a_par_in = 2'b00;
        b_data_in = 16'h0103; b_par_in = 2'b00;
        @(negedge clk);
        ab_oe_n = 1'b1;
        #1;
        cmp("R8 ab flag masked", 32'(ab_err_n), 32'h1);
        cmp("R8 b drive off", 32'(b_drv_en), 32'h0);
        cmp("R8 a drive on", 32'(a_drv_en), 32'h1);
        cmp("R8 ba flag live", 32'(ba_err_n), 32'h0);
        ab_oe_n = 1'b0;
        ba_oe_n = 1'b1;
        #1;
        cmp("R8 ab flag back", 32'(ab_err_n), 32'h0);
        cmp("R8 ba flag masked", 32'(ba_err_n), 32'h1);
        cmp("R8 a drive off", 32'(a_drv_en), 32'h0);
        ba_oe_n = 1'b0;

        // R3 latched: A-to-B clock stopped, B-to-A keeps capturing
        @(negedge clk);
        run_ab = 1'b0;
        a_data_in = 16'hFFFF; a_par_in = 2'b11;
        b_data_in = 16'h8001; b_par_in = 2'b00;
        repeat (4) @(negedge clk);
        #1;
        cmp("R3 b data held", 32'(b_data_out), 32'h0103);
        cmp("R3 ab fault held", 32'(ab_err_n), 32'h0);
        cmp("R3 other path moves", 32'(a_data_out), 32'h8001);
        cmp("R3 other path clean", 32'(ba_err_n), 32'h1);
        run_ab = 1'b1;
        @(negedge clk);
        #1;
        cmp("R3 resumes on edge", 32'(b_data_out), 32'hFFFF);

        // R6 mode select does not reach B-to-A
        ba_le = 1'b1;
        b_data_in = 16'h0103; b_par_in = 2'b00;
        ab_gen = 1'b1;
        #1;
        cmp("R6 gen high flag", 32'(ba_err_n), 32'h0);
        cmp("R6 gen high par", 32'(a_par_out), 32'h0);
        ab_gen = 1'b0;
        #1;
        cmp("R6 gen low flag", 32'(ba_err_n), 32'h0);

        // R9 shared sense
        @(negedge clk);
        ab_le = 1'b1;
        a_data_in = 16'h0303; a_par_in = 2'b00;
        b_data_in = 16'h0303; b_par_in = 2'b00;
        odd_sel = 1'b1;
        #1;
        cmp("R9 odd ab", 32'(ab_err_n), 32'h0);
        cmp("R9 odd ba", 32'(ba_err_n), 32'h0);
        @(negedge clk);
        odd_sel = 1'b0;
        #1;
        cmp("R9 even ab", 32'(ab_err_n), 32'h1);
        cmp("R9 even ba", 32'(ba_err_n), 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule